// File: doc/BRIEF.md
# Accumulator Processor Core with Port-Mapped I/O

This block is a small processor core built around one 16-bit accumulator. Each instruction word is 16 bits wide: the top four bits choose the operation and the low twelve bits carry either a memory word address or an I/O device number. The core fetches a word into its instruction register in one step. It then carries the instruction out in a later step. The program counter moves forward by one word per instruction.

Memory is a synchronous, word-addressed port. A read strobe with an address returns data on the read-data input one cycle later, and a write strobe stores the write data at that edge. I/O uses its own port with a device number, a read strobe and a write strobe. A device answers a read strobe one cycle later, in the same way memory does. Opcode 1 loads the accumulator from memory, 2 stores it to memory and 5 adds a memory word to it. Opcode 3 reads an I/O device into it and opcode 7 writes it to a device. Every other opcode stops the core until the next reset.

Top module: `acc_core`

## Requirements
- R1: While and right after the synchronous reset, the core drives one memory read at address PC_RESET, with no other strobe active and `halted` low.
- R2: Instruction fetches move through consecutive word addresses starting at PC_RESET. A data access never changes the next fetch address.
- R3: Opcode 1 loads the memory word at the 12-bit address (bits 11:0) into the accumulator, replacing its old value.
- R4: Opcode 2 raises `mem_wr` for one cycle, with `mem_addr` equal to bits 11:0 of the instruction and `mem_wdata` equal to the accumulator.
- R5: Opcode 5 adds the memory word at the 12-bit address to the accumulator, and the sum wraps modulo 2^16.
- R6: Opcode 3 raises `io_rd` for exactly one cycle with `io_dev` equal to bits 11:0. The accumulator then takes the value the device returns in the following cycle.
- R7: Opcode 7 raises `io_wr` for exactly one cycle, with `io_dev` equal to bits 11:0 and `io_wdata` equal to the accumulator.
- R8: Any opcode other than 1, 2, 3, 5 or 7 sets `halted`. After that no strobe is active and no further word is fetched until reset.
- R9: At most one of `mem_rd`, `mem_wr`, `io_rd`, `io_wr` is active in any cycle.
- R10: The opcode is taken from bits 15:12 and the operand from bits 11:0. The program {3005, 5940, 7006} hex at 300 hex, with 0002 at 940 hex and device 5 returning 3, writes 5 to device 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the cycle after `mem_rd` |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_dev | output | 12 | I/O device number |
| io_wdata | output | 16 | I/O write data |
| io_rdata | input | 16 | I/O read data, valid the cycle after `io_rd` |
| halted | output | 1 | Core has stopped on an unsupported opcode |

## Verification
The bench runs the three-instruction I/O program. A core that mixed up the device field with a memory address, or that fetched the operand from memory, would write something other than 5 to device 6, or would make an extra memory read. An add that reaches past 16 bits checks the wrap; a design that kept a carry or saturated would store a value other than 2. A halting opcode in the middle of a program must stop all later fetches and strobes. A core that treated it as a no-op would go on to issue the store that follows it. A reset after a halt must restart fetching at the reset address. A core that kept its old program counter or halt flag would fetch from the wrong place or stay stopped.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam logic [3:0] OPC_LOAD  = 4'h1;
  localparam logic [3:0] OPC_STORE = 4'h2;
  localparam logic [3:0] OPC_IN    = 4'h3;
  localparam logic [3:0] OPC_ADD   = 4'h5;
  localparam logic [3:0] OPC_OUT   = 4'h7;

  typedef enum logic [2:0] {
    K_LOAD, K_STORE, K_ADD, K_IN, K_OUT, K_HALT
  } op_kind_t;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_WB, ST_HALT
  } core_state_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OP_W   = 4
) (
  input  logic [DATA_W-1:0] word,
  output op_kind_t          kind
);
  localparam int ADDR_W = DATA_W - OP_W;

  logic [OP_W-1:0] opc;
  assign opc = word[DATA_W-1:ADDR_W];

  always_comb begin
    unique case (opc)
      OPC_LOAD:  kind = K_LOAD;
      OPC_STORE: kind = K_STORE;
      OPC_ADD:   kind = K_ADD;
      OPC_IN:    kind = K_IN;
      OPC_OUT:   kind = K_OUT;
      default:   kind = K_HALT;
    endcase
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_en,
  input  op_kind_t          wb_kind,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] io_rdata,
  output logic [DATA_W-1:0] acc
);
  logic [DATA_W-1:0] sum;
  assign sum = acc + mem_rdata;  // wraps at DATA_W bits

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (wb_en) begin
      case (wb_kind)
        K_LOAD:  acc <= mem_rdata;
        K_ADD:   acc <= sum;
        K_IN:    acc <= io_rdata;
        default: acc <= acc;
      endcase
    end
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int OP_W     = 4,
  parameter int PC_RESET = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DATA_W-1:0]        mem_rdata,
  input  logic [DATA_W-1:0]        acc,
  output logic                     wb_en,
  output op_kind_t                 wb_kind,
  output logic                     mem_rd,
  output logic                     mem_wr,
  output logic [DATA_W-OP_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic                     io_rd,
  output logic                     io_wr,
  output logic [DATA_W-OP_W-1:0]   io_dev,
  output logic [DATA_W-1:0]        io_wdata,
  output logic                     halted
);
  localparam int ADDR_W = DATA_W - OP_W;
  localparam logic [ADDR_W-1:0] PC_INIT = ADDR_W'(PC_RESET);

  core_state_t       state;
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir;
  op_kind_t          kind_new;
  op_kind_t          kind_ir;

  acc_decode #(.DATA_W(DATA_W), .OP_W(OP_W)) u_dec_new (
    .word(mem_rdata), .kind(kind_new)
  );
  acc_decode #(.DATA_W(DATA_W), .OP_W(OP_W)) u_dec_ir (
    .word(ir), .kind(kind_ir)
  );

  assign wb_en   = (state == ST_WB);
  assign wb_kind = kind_ir;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FETCH;
      pc        <= PC_INIT;
      ir        <= '0;
      mem_rd    <= 1'b1;
      mem_wr    <= 1'b0;
      mem_addr  <= PC_INIT;
      mem_wdata <= '0;
      io_rd     <= 1'b0;
      io_wr     <= 1'b0;
      io_dev    <= '0;
      io_wdata  <= '0;
      halted    <= 1'b0;
    end else begin
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      io_rd  <= 1'b0;
      io_wr  <= 1'b0;
      case (state)
        ST_FETCH: state <= ST_DECODE;
        ST_DECODE: begin
          ir    <= mem_rdata;
          pc    <= pc + 1'b1;
          state <= ST_EXEC;
          case (kind_new)
            K_LOAD, K_ADD: begin
              mem_rd   <= 1'b1;
              mem_addr <= mem_rdata[ADDR_W-1:0];
            end
            K_STORE: begin
              mem_wr    <= 1'b1;
              mem_addr  <= mem_rdata[ADDR_W-1:0];
              mem_wdata <= acc;
            end
            K_IN: begin
              io_rd  <= 1'b1;
              io_dev <= mem_rdata[ADDR_W-1:0];
            end
            K_OUT: begin
              io_wr    <= 1'b1;
              io_dev   <= mem_rdata[ADDR_W-1:0];
              io_wdata <= acc;
            end
            default: begin
              halted <= 1'b1;
              state  <= ST_HALT;
            end
          endcase
        end
        ST_EXEC: begin
          if (kind_ir == K_LOAD || kind_ir == K_ADD || kind_ir == K_IN) begin
            state <= ST_WB;
          end else begin
            state    <= ST_FETCH;
            mem_rd   <= 1'b1;
            mem_addr <= pc;
          end
        end
        ST_WB: begin
          state    <= ST_FETCH;
          mem_rd   <= 1'b1;
          mem_addr <= pc;
        end
        default: state <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int OP_W     = 4,
  parameter int PC_RESET = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  output logic                   mem_rd,
  output logic                   mem_wr,
  output logic [DATA_W-OP_W-1:0] mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic [DATA_W-1:0]      mem_rdata,
  output logic                   io_rd,
  output logic                   io_wr,
  output logic [DATA_W-OP_W-1:0] io_dev,
  output logic [DATA_W-1:0]      io_wdata,
  input  logic [DATA_W-1:0]      io_rdata,
  output logic                   halted
);
  logic [DATA_W-1:0] acc;
  logic              wb_en;
  op_kind_t          wb_kind;

  acc_seq #(.DATA_W(DATA_W), .OP_W(OP_W), .PC_RESET(PC_RESET)) u_seq (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .acc(acc),
    .wb_en(wb_en), .wb_kind(wb_kind),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_dev(io_dev), .io_wdata(io_wdata),
    .halted(halted)
  );

  acc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .wb_en(wb_en), .wb_kind(wb_kind),
    .mem_rdata(mem_rdata), .io_rdata(io_rdata), .acc(acc)
  );
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DATA_W   = 16,
  parameter int OP_W     = 4,
  parameter int PC_RESET = 0
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   mem_rd,
  input logic                   mem_wr,
  input logic [DATA_W-OP_W-1:0] mem_addr,
  input logic                   io_rd,
  input logic                   io_wr,
  input logic                   halted
);
  localparam int ADDR_W = DATA_W - OP_W;

  a_r1_reset_fetch: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_rd && !mem_wr && !io_rd && !io_wr && !halted
                    && mem_addr == ADDR_W'(PC_RESET)));

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $countones({mem_rd, mem_wr, io_rd, io_wr}) <= 1);

  a_r6_io_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    io_rd |=> !io_rd);

  a_r7_io_wr_pulse: assert property (@(posedge clk) disable iff (rst)
    io_wr |=> !io_wr);

  a_r4_wr_then_fetch: assert property (@(posedge clk) disable iff (rst)
    (mem_wr || io_wr) |=> mem_rd);

  a_r8_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_rd && !mem_wr && !io_rd && !io_wr));
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .OP_W(OP_W), .PC_RESET(PC_RESET)) u_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
  .io_rd(io_rd), .io_wr(io_wr), .halted(halted)
);

// File: tb/acc_core_tb.sv
module acc_core_tb;
  localparam int DATA_W = 16;
  localparam int OP_W   = 4;
  localparam int ADDR_W = DATA_W - OP_W;
  localparam int PC0    = 'h300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mem_rd, mem_wr, io_rd, io_wr, halted;
  logic [ADDR_W-1:0] mem_addr, io_dev;
  logic [DATA_W-1:0] mem_wdata, io_wdata;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic [DATA_W-1:0] io_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [DATA_W-1:0] mem [1 << ADDR_W];
  logic [DATA_W-1:0] dev_src [16];
  logic [ADDR_W-1:0] rd_log [64];
  int rd_cnt, wr_cnt, out_cnt, in_cnt, multi_cnt, strobe_after_halt;
  logic [ADDR_W-1:0] last_wr_addr, last_out_dev, last_in_dev;
  logic [DATA_W-1:0] last_wr_data, last_out_data;

  always #10 clk = ~clk;

  acc_core #(.DATA_W(DATA_W), .OP_W(OP_W), .PC_RESET(PC0)) u_dut (
    .clk(clk), .rst(rst),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_dev(io_dev), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .halted(halted)
  );

  // Memory and device models, synchronous with one cycle of read latency
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr];
      if (!rst && rd_cnt < 64) rd_log[rd_cnt] <= mem_addr;
      if (!rst) rd_cnt <= rd_cnt + 1;
    end
    if (mem_wr) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
      last_wr_addr <= mem_addr;
      last_wr_data <= mem_wdata;
    end
    if (io_rd) begin
      io_rdata <= dev_src[io_dev[3:0]];
      in_cnt <= in_cnt + 1;
      last_in_dev <= io_dev;
    end
    if (io_wr) begin
      out_cnt <= out_cnt + 1;
      last_out_dev <= io_dev;
      last_out_data <= io_wdata;
    end
    if (!rst && (32'(mem_rd) + 32'(mem_wr) + 32'(io_rd) + 32'(io_wr)) > 1)
      multi_cnt <= multi_cnt + 1;
    if (!rst && halted && (mem_rd || mem_wr || io_rd || io_wr))
      strobe_after_halt <= strobe_after_halt + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 16'hF000;
    for (int i = 0; i < 16; i++) dev_src[i] = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; out_cnt = 0; in_cnt = 0;
    multi_cnt = 0; strobe_after_halt = 0;
    rst = 1'b0;
  endtask

  task automatic run_to_halt(input string req);
    int n = 0;
    while (!halted && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(halted == 1'b1, req, "halt reached", halted, 1);
  endtask

  task automatic t_reset();
    clear_all();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(mem_rd == 1'b1, "R1", "fetch strobe in reset", mem_rd, 1);
    check(mem_addr == ADDR_W'(PC0), "R1", "fetch address", mem_addr, PC0);
    check({mem_wr, io_rd, io_wr, halted} == 4'b0, "R1", "other outputs idle",
          {mem_wr, io_rd, io_wr, halted}, 0);
  endtask

  // R10 / R2 / R6 / R7 / R5: three-instruction I/O program
  task automatic t_io_program();
    clear_all();
    mem['h300] = 16'h3005;
    mem['h301] = 16'h5940;
    mem['h302] = 16'h7006;
    mem['h940] = 16'h0002;
    dev_src[5] = 16'h0003;
    do_reset();
    run_to_halt("R10");
    repeat (2) @(negedge clk);
    check(out_cnt == 1, "R7", "device write count", out_cnt, 1);
    check(last_out_dev == 12'h006, "R7", "device number", last_out_dev, 6);
    check(last_out_data == 16'h0005, "R10", "value sent to device 6", last_out_data, 5);
    check(in_cnt == 1 && last_in_dev == 12'h005, "R6", "device read",
          last_in_dev, 5);
    check(rd_cnt == 5, "R2", "memory read count", rd_cnt, 5);
    check(rd_log[0] == 12'h300 && rd_log[1] == 12'h301, "R2", "first fetches",
          {rd_log[0], rd_log[1]}, 24'h300301);
    check(rd_log[2] == 12'h940, "R5", "add operand address", rd_log[2], 'h940);
    check(rd_log[3] == 12'h302 && rd_log[4] == 12'h303, "R2", "later fetches",
          {rd_log[3], rd_log[4]}, 24'h302303);
    check(wr_cnt == 0, "R6", "no memory write from I/O program", wr_cnt, 0);
  endtask

  // R3 / R4 / R5: load, add with wrap, store
  task automatic t_wrap_store();
    clear_all();
    mem['h300] = 16'h1010;
    mem['h301] = 16'h5011;
    mem['h302] = 16'h2020;
    mem['h303] = 16'h0000;
    mem['h010] = 16'hFFFF;
    mem['h011] = 16'h0003;
    do_reset();
    run_to_halt("R3");
    repeat (2) @(negedge clk);
    check(wr_cnt == 1, "R4", "store count", wr_cnt, 1);
    check(last_wr_addr == 12'h020, "R4", "store address", last_wr_addr, 'h20);
    check(last_wr_data == 16'h0002, "R5", "wrapped sum", last_wr_data, 2);
    check(mem['h020] == 16'h0002, "R3", "memory after store", mem['h020], 2);
    check(out_cnt == 0 && in_cnt == 0, "R4", "no I/O strobes", out_cnt, 0);
  endtask

  // R3: load replaces, then R7 write out via I/O
  task automatic t_load_replace();
    clear_all();
    mem['h300] = 16'h1050;
    mem['h301] = 16'h1051;
    mem['h302] = 16'h7003;
    mem['h050] = 16'h1234;
    mem['h051] = 16'hABCD;
    do_reset();
    run_to_halt("R3");
    repeat (2) @(negedge clk);
    check(last_out_data == 16'hABCD, "R3", "second load replaces first",
          last_out_data, 'hABCD);
    check(last_out_dev == 12'h003, "R7", "device number", last_out_dev, 3);
  endtask

  // R8: halt stops the store behind it; reset restarts
  task automatic t_halt();
    clear_all();
    mem['h300] = 16'h1010;
    mem['h301] = 16'hA123;
    mem['h302] = 16'h2020;
    mem['h010] = 16'h0042;
    do_reset();
    run_to_halt("R8");
    repeat (20) @(negedge clk);
    check(wr_cnt == 0, "R8", "store after halt suppressed", wr_cnt, 0);
    check(rd_cnt == 3, "R8", "no fetch after halt", rd_cnt, 3);
    check(strobe_after_halt == 0, "R8", "strobes while halted", strobe_after_halt, 0);
    check(halted == 1'b1, "R8", "halt holds", halted, 1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(halted == 1'b0 && mem_rd == 1'b1 && mem_addr == ADDR_W'(PC0), "R1",
          "reset after halt restarts fetch", mem_addr, PC0);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_io_program();
    check(multi_cnt == 0, "R9", "overlapping strobes", multi_cnt, 0);
    t_wrap_store();
    t_load_replace();
    t_halt();
    check(multi_cnt == 0, "R9", "overlapping strobes", multi_cnt, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles >= 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule